// File: doc/BRIEF.md
# SPI Master Register and FIFO Front End

This block is the register-mapped side of an SPI master. A host reaches it through a simple 32-bit bus with separate write and read strobes and a byte address. It holds the setup for the serial engine: enable, clock divider and edge options, word formats for each direction, and frame-select options. These settings appear on plain configuration outputs. Two small FIFOs sit between the host and the engine, and both are reached through one data address. A write to that address queues a transmit word. A read from it takes the oldest received word.

The engine itself is outside this block. Toward it, the block shows the head of the transmit queue with a valid flag and accepts pop pulses. It also accepts received words with a push strobe, and it takes a busy level and a transfer-done pulse. The block keeps three sticky event flags: receive overrun, receive level reached, and transfer done. Each flag can be masked into a single interrupt line and is cleared by writing a one. Writing a FIFO flush bit empties that FIFO one cycle later, and the bit clears itself.

Top module: `spi_regfront`

## Requirements
- R1: After reset every setting reads 0, the status word (offset 0x14) reads 0x20 (only transmit-not-full set), no event flag is pending and irq is low.
- R2: The setting registers read back only their defined fields, and each field drives its configuration output. Offset 0x00 bit 0 is enable. At 0x04, bits 7:0 are the divider, bit 12 the delay, bit 13 the idle level and bit 14 the capture edge. At 0x08, bits 13:8 are the word length, bits 7:6 the format and bits 5:0 the data length. At 0x0C, bits 7:6 are the format and bits 5:0 the data length. At 0x10, bit 14 is the frame start and bit 15 the frame polarity. At 0x18, bits 4, 3 and 0 are the interrupt masks. All other bits read 0.
- R3: Words written to offset 0x24 reach the engine in write order, and tx_valid is high while the transmit FIFO holds a word.
- R4: The transmit FIFO holds 8 words. When it is full, status bit 5 reads 0 and a further write to 0x24 is dropped.
- R5: Words the engine pushes are read from offset 0x24 in arrival order. Status bit 0 is 1 while the receive FIFO holds a word.
- R6: A read of 0x24 with the receive FIFO empty returns 0 and changes no state.
- R7: An engine push while the receive FIFO is full discards the word and sets the overrun flag. The flags read at offset 0x1C: bit 0 is overrun, bit 3 is receive level, bit 4 is transfer done.
- R8: Writing 1 to offset 0x20 bit 12 (transmit) or bit 4 (receive) empties that FIFO one cycle later. These bits always read 0. Bits 11:8 and 3:0 hold the transmit and receive thresholds.
- R9: Writing 1 to a flag bit at 0x1C clears that flag. Writing 0 to it leaves it unchanged.
- R10: irq is high exactly when some pending flag has its mask bit set at 0x18.
- R11: The receive-level flag sets when an accepted push brings the receive FIFO to at least the receive threshold.
- R12: A done pulse from the engine sets the transfer-done flag. Status bit 7 follows the engine busy input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive FIFO at 0x24) |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| cfg_enable | output | 1 | Controller enable |
| cfg_clk_div | output | 8 | Serial clock divider |
| cfg_clk_delay | output | 1 | Clock delay option |
| cfg_clk_idle | output | 1 | Clock idle level |
| cfg_clk_capture | output | 1 | Capture edge select |
| cfg_frame_start | output | 1 | Frame start edge |
| cfg_frame_pol | output | 1 | Frame select polarity |
| cfg_tx_wordlen | output | 6 | Transmit word length |
| cfg_tx_fmt | output | 2 | Transmit bit order format |
| cfg_tx_datalen | output | 6 | Transmit data length |
| cfg_rx_fmt | output | 2 | Receive bit order format |
| cfg_rx_datalen | output | 6 | Receive data length |
| cfg_tx_thresh | output | 4 | Transmit FIFO threshold |
| cfg_rx_thresh | output | 4 | Receive FIFO threshold |
| eng_tx_valid | output | 1 | Transmit FIFO has a word |
| eng_tx_data | output | 32 | Oldest transmit word |
| eng_tx_pop | input | 1 | Engine takes the transmit head |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | 32 | Received word |
| eng_busy | input | 1 | Engine busy level |
| eng_done | input | 1 | Transfer-done pulse |
| irq | output | 1 | Masked interrupt |

## Verification
The transmit path runs with short bursts, with an exact fill to eight words, and with an extra write past full. A scoreboard queue then shows whether the dropped word leaks out or the order slips. The receive path runs with pushes below capacity and with nine pushes into eight slots, which separates a correct discard from a wrapped overwrite. Reads of an empty queue followed by a fresh push show whether an idle read moved a pointer. Flag, mask and flush writes use all-ones, zero and single-bit patterns, which separates write-one-to-clear from plain storage and self-clearing flush bits from stored ones.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;

    localparam logic [5:0] OFF_CTRL  = 6'h00;
    localparam logic [5:0] OFF_CLK   = 6'h04;
    localparam logic [5:0] OFF_TXF   = 6'h08;
    localparam logic [5:0] OFF_RXF   = 6'h0C;
    localparam logic [5:0] OFF_FRAME = 6'h10;
    localparam logic [5:0] OFF_STAT  = 6'h14;
    localparam logic [5:0] OFF_MASK  = 6'h18;
    localparam logic [5:0] OFF_FLAG  = 6'h1C;
    localparam logic [5:0] OFF_FIFO  = 6'h20;
    localparam logic [5:0] OFF_DATA  = 6'h24;

    localparam int NUM_FLAGS = 3;
    localparam int FLG_OVR  = 0;
    localparam int FLG_RXL  = 1;
    localparam int FLG_DONE = 2;

    typedef struct packed {
        logic       en;
        logic [7:0] div;
        logic       ck_dly;
        logic       ck_idle;
        logic       ck_cap;
        logic [5:0] tx_wlen;
        logic [1:0] tx_fmt;
        logic [5:0] tx_dlen;
        logic [1:0] rx_fmt;
        logic [5:0] rx_dlen;
        logic       fr_start;
        logic       fr_pol;
        logic [3:0] tx_th;
        logic [3:0] rx_th;
        logic [NUM_FLAGS-1:0] mask;
        logic       tx_flush;
        logic       rx_flush;
    } regs_t;

endpackage

// File: rtl/spi_rf_fifo.sv
module spi_rf_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic                         full,
    output logic                         empty,
    output logic [$clog2(DEPTH+1)-1:0]   level
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t q, d;
    logic do_push, do_pop;

    assign full  = (q.cnt == CW'(DEPTH));
    assign empty = (q.cnt == '0);
    assign level = q.cnt;
    assign dout  = q.mem[q.rp];

    always_comb begin
        d       = q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (flush) begin
            d.wp  = '0;
            d.rp  = '0;
            d.cnt = '0;
        end else begin
            if (do_push) begin
                d.mem[q.wp] = din;
                d.wp = (q.wp == PW'(DEPTH-1)) ? '0 : q.wp + 1'b1;
            end
            if (do_pop) begin
                d.rp = (q.rp == PW'(DEPTH-1)) ? '0 : q.rp + 1'b1;
            end
            if (do_push && !do_pop)      d.cnt = q.cnt + 1'b1;
            else if (do_pop && !do_push) d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(DEPTH)) else $error("fifo level beyond depth"); // R4
    AST_FIFO_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        full && push && !pop && !flush |=> $stable(level)) else $error("push into full fifo"); // R4
    AST_FIFO_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        empty && pop && !push && !flush |=> empty) else $error("pop of empty fifo"); // R6
    AST_FIFO_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty) else $error("flush left entries"); // R8
endmodule

// File: rtl/spi_rf_irq.sv
module spi_rf_irq #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_ev,
    input  logic [N-1:0] clr_ev,
    input  logic [N-1:0] mask,
    output logic [N-1:0] flags,
    output logic         irq
);
    typedef struct packed {
        logic [N-1:0] pend;
    } irq_st_t;

    irq_st_t q, d;

    always_comb begin
        d = q;
        for (int i = 0; i < N; i++) begin
            if (set_ev[i])      d.pend[i] = 1'b1;
            else if (clr_ev[i]) d.pend[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign flags = q.pend;
    assign irq   = |(q.pend & mask);

    AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        |set_ev |=> |flags) else $error("event lost"); // R7
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ev == {N{1'b1}}) && (set_ev == '0) |=> (flags == '0)) else $error("clear ignored"); // R9
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq) else $error("irq with all masked"); // R10
endmodule

// File: rtl/spi_regfront.sv
module spi_regfront #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [5:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              cfg_enable,
    output logic [7:0]        cfg_clk_div,
    output logic              cfg_clk_delay,
    output logic              cfg_clk_idle,
    output logic              cfg_clk_capture,
    output logic              cfg_frame_start,
    output logic              cfg_frame_pol,
    output logic [5:0]        cfg_tx_wordlen,
    output logic [1:0]        cfg_tx_fmt,
    output logic [5:0]        cfg_tx_datalen,
    output logic [1:0]        cfg_rx_fmt,
    output logic [5:0]        cfg_rx_datalen,
    output logic [3:0]        cfg_tx_thresh,
    output logic [3:0]        cfg_rx_thresh,
    output logic              eng_tx_valid,
    output logic [DATA_W-1:0] eng_tx_data,
    input  logic              eng_tx_pop,
    input  logic              eng_rx_push,
    input  logic [DATA_W-1:0] eng_rx_data,
    input  logic              eng_busy,
    input  logic              eng_done,
    output logic              irq
);
    import spi_rf_pkg::*;

    localparam int CW = $clog2(DEPTH+1);

    regs_t q, d;

    logic              wr_ctrl, wr_clk, wr_txf, wr_rxf, wr_frame;
    logic              wr_mask, wr_flag, wr_fifo, wr_data, rd_data;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic [CW-1:0]     tx_level, rx_level;
    logic [DATA_W-1:0] rx_head;
    logic              rx_accept;
    logic [NUM_FLAGS-1:0] set_ev, clr_ev, flags;

    assign wr_ctrl  = bus_wr && (bus_addr == OFF_CTRL);
    assign wr_clk   = bus_wr && (bus_addr == OFF_CLK);
    assign wr_txf   = bus_wr && (bus_addr == OFF_TXF);
    assign wr_rxf   = bus_wr && (bus_addr == OFF_RXF);
    assign wr_frame = bus_wr && (bus_addr == OFF_FRAME);
    assign wr_mask  = bus_wr && (bus_addr == OFF_MASK);
    assign wr_flag  = bus_wr && (bus_addr == OFF_FLAG);
    assign wr_fifo  = bus_wr && (bus_addr == OFF_FIFO);
    assign wr_data  = bus_wr && (bus_addr == OFF_DATA);
    assign rd_data  = bus_rd && (bus_addr == OFF_DATA);

    // next-state for the setting registers and flush strobes
    always_comb begin
        d          = q;
        d.tx_flush = 1'b0;
        d.rx_flush = 1'b0;
        if (wr_ctrl) d.en = bus_wdata[0];
        if (wr_clk) begin
            d.div     = bus_wdata[7:0];
            d.ck_dly  = bus_wdata[12];
            d.ck_idle = bus_wdata[13];
            d.ck_cap  = bus_wdata[14];
        end
        if (wr_txf) begin
            d.tx_wlen = bus_wdata[13:8];
            d.tx_fmt  = bus_wdata[7:6];
            d.tx_dlen = bus_wdata[5:0];
        end
        if (wr_rxf) begin
            d.rx_fmt  = bus_wdata[7:6];
            d.rx_dlen = bus_wdata[5:0];
        end
        if (wr_frame) begin
            d.fr_start = bus_wdata[14];
            d.fr_pol   = bus_wdata[15];
        end
        if (wr_mask) d.mask = {bus_wdata[4], bus_wdata[3], bus_wdata[0]};
        if (wr_fifo) begin
            d.tx_flush = bus_wdata[12];
            d.rx_flush = bus_wdata[4];
            d.tx_th    = bus_wdata[11:8];
            d.rx_th    = bus_wdata[3:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    spi_rf_fifo #(.DEPTH(DEPTH), .W(DATA_W)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (q.tx_flush),
        .push  (wr_data),
        .din   (bus_wdata[DATA_W-1:0]),
        .pop   (eng_tx_pop),
        .dout  (eng_tx_data),
        .full  (tx_full),
        .empty (tx_empty),
        .level (tx_level)
    );

    spi_rf_fifo #(.DEPTH(DEPTH), .W(DATA_W)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (q.rx_flush),
        .push  (eng_rx_push),
        .din   (eng_rx_data),
        .pop   (rd_data),
        .dout  (rx_head),
        .full  (rx_full),
        .empty (rx_empty),
        .level (rx_level)
    );

    assign rx_accept        = eng_rx_push && !rx_full && !q.rx_flush;
    assign set_ev[FLG_OVR]  = eng_rx_push && rx_full && !q.rx_flush;
    assign set_ev[FLG_RXL]  = rx_accept && ((int'(rx_level) + 1) >= int'(q.rx_th));
    assign set_ev[FLG_DONE] = eng_done;
    assign clr_ev           = wr_flag ? {bus_wdata[4], bus_wdata[3], bus_wdata[0]} : '0;

    spi_rf_irq #(.N(NUM_FLAGS)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_ev (set_ev),
        .clr_ev (clr_ev),
        .mask   (q.mask),
        .flags  (flags),
        .irq    (irq)
    );

    // read mux
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFF_CTRL:  bus_rdata[0] = q.en;
            OFF_CLK:   begin
                bus_rdata[7:0] = q.div;
                bus_rdata[12]  = q.ck_dly;
                bus_rdata[13]  = q.ck_idle;
                bus_rdata[14]  = q.ck_cap;
            end
            OFF_TXF:   bus_rdata[13:0] = {q.tx_wlen, q.tx_fmt, q.tx_dlen};
            OFF_RXF:   bus_rdata[7:0]  = {q.rx_fmt, q.rx_dlen};
            OFF_FRAME: bus_rdata[15:14] = {q.fr_pol, q.fr_start};
            OFF_STAT:  begin
                bus_rdata[7] = eng_busy;
                bus_rdata[5] = !tx_full;
                bus_rdata[0] = !rx_empty;
            end
            OFF_MASK:  begin
                bus_rdata[4] = q.mask[FLG_DONE];
                bus_rdata[3] = q.mask[FLG_RXL];
                bus_rdata[0] = q.mask[FLG_OVR];
            end
            OFF_FLAG:  begin
                bus_rdata[4] = flags[FLG_DONE];
                bus_rdata[3] = flags[FLG_RXL];
                bus_rdata[0] = flags[FLG_OVR];
            end
            OFF_FIFO:  begin
                bus_rdata[11:8] = q.tx_th;
                bus_rdata[3:0]  = q.rx_th;
            end
            OFF_DATA:  bus_rdata = rx_empty ? 32'd0 : 32'(rx_head);
            default:   bus_rdata = '0;
        endcase
    end

    assign cfg_enable      = q.en;
    assign cfg_clk_div     = q.div;
    assign cfg_clk_delay   = q.ck_dly;
    assign cfg_clk_idle    = q.ck_idle;
    assign cfg_clk_capture = q.ck_cap;
    assign cfg_frame_start = q.fr_start;
    assign cfg_frame_pol   = q.fr_pol;
    assign cfg_tx_wordlen  = q.tx_wlen;
    assign cfg_tx_fmt      = q.tx_fmt;
    assign cfg_tx_datalen  = q.tx_dlen;
    assign cfg_rx_fmt      = q.rx_fmt;
    assign cfg_rx_datalen  = q.rx_dlen;
    assign cfg_tx_thresh   = q.tx_th;
    assign cfg_rx_thresh   = q.rx_th;
    assign eng_tx_valid    = !tx_empty;

    logic unused_sig;
    assign unused_sig = ^{bus_wdata, tx_level};

    AST_FLUSH_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        q.tx_flush || q.rx_flush |=> !(q.tx_flush && $past(q.tx_flush) && !$past(wr_fifo)))
        else $error("flush bit stuck"); // R8
    AST_OVERRUN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        eng_rx_push && rx_full && !q.rx_flush |=> flags[FLG_OVR]) else $error("overrun missed"); // R7
    AST_OVERRUN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        eng_rx_push && rx_full && !rd_data && !q.rx_flush |=> rx_full) else $error("overrun changed fifo"); // R7
    AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> flags[FLG_DONE]) else $error("done missed"); // R12
endmodule

// File: tb/spi_regfront_bench.sv
`timescale 1ns/1ps
module spi_regfront_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cfg_enable, cfg_clk_delay, cfg_clk_idle, cfg_clk_capture;
    logic        cfg_frame_start, cfg_frame_pol;
    logic [7:0]  cfg_clk_div;
    logic [5:0]  cfg_tx_wordlen, cfg_tx_datalen, cfg_rx_datalen;
    logic [1:0]  cfg_tx_fmt, cfg_rx_fmt;
    logic [3:0]  cfg_tx_thresh, cfg_rx_thresh;
    logic        eng_tx_valid;
    logic [31:0] eng_tx_data;
    logic        eng_tx_pop = 1'b0, eng_rx_push = 1'b0, eng_busy = 1'b0, eng_done = 1'b0;
    logic [31:0] eng_rx_data = '0;
    logic        irq;

    int total = 0, fails = 0;
    bit done = 0;
    logic [31:0] tx_q[$];
    logic [31:0] rx_q[$];

    always #2.5 clk = ~clk;

    spi_regfront u_spi_regfront (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_enable(cfg_enable),
        .cfg_clk_div(cfg_clk_div), .cfg_clk_delay(cfg_clk_delay), .cfg_clk_idle(cfg_clk_idle),
        .cfg_clk_capture(cfg_clk_capture), .cfg_frame_start(cfg_frame_start),
        .cfg_frame_pol(cfg_frame_pol), .cfg_tx_wordlen(cfg_tx_wordlen), .cfg_tx_fmt(cfg_tx_fmt),
        .cfg_tx_datalen(cfg_tx_datalen), .cfg_rx_fmt(cfg_rx_fmt), .cfg_rx_datalen(cfg_rx_datalen),
        .cfg_tx_thresh(cfg_tx_thresh), .cfg_rx_thresh(cfg_rx_thresh), .eng_tx_valid(eng_tx_valid),
        .eng_tx_data(eng_tx_data), .eng_tx_pop(eng_tx_pop), .eng_rx_push(eng_rx_push),
        .eng_rx_data(eng_rx_data), .eng_busy(eng_busy), .eng_done(eng_done), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic read_check(input string req, input logic [5:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_read(a, v);
        check(req, v, exp);
    endtask

    // driver: queue a transmit word, recording it when it should be accepted
    task automatic tx_send(input logic [31:0] v, input bit accept);
        bus_write(6'h24, v);
        if (accept) tx_q.push_back(v);
    endtask

    // monitor: engine side takes the head and compares with the scoreboard
    task automatic eng_take(input string req);
        logic [31:0] exp;
        @(negedge clk);
        check({req, " valid"}, 32'(eng_tx_valid), 32'd1);
        exp = (tx_q.size() > 0) ? tx_q.pop_front() : 32'hxxxx_xxxx;
        check(req, eng_tx_data, exp);
        eng_tx_pop = 1'b1;
        @(negedge clk);
        eng_tx_pop = 1'b0;
    endtask

    task automatic eng_push(input logic [31:0] v, input bit accept);
        @(negedge clk);
        eng_rx_push = 1'b1; eng_rx_data = v;
        @(negedge clk);
        eng_rx_push = 1'b0;
        if (accept) rx_q.push_back(v);
    endtask

    task automatic rx_drain(input string req);
        while (rx_q.size() > 0) read_check(req, 6'h24, rx_q.pop_front());
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        read_check("R1 ctrl", 6'h00, 32'h0);
        read_check("R1 status", 6'h14, 32'h20);
        read_check("R1 flags", 6'h1C, 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
        check("R1 tx_valid", 32'(eng_tx_valid), 32'h0);

        // R2 field readback and outputs
        bus_write(6'h00, 32'hFFFF_FFFF); read_check("R2 ctrl", 6'h00, 32'h1);
        check("R2 enable out", 32'(cfg_enable), 32'h1);
        bus_write(6'h04, 32'hFFFF_FFFF); read_check("R2 clk", 6'h04, 32'h0000_70FF);
        check("R2 div out", 32'(cfg_clk_div), 32'hFF);
        bus_write(6'h08, 32'hFFFF_FFFF); read_check("R2 txfmt", 6'h08, 32'h3FFF);
        check("R2 wordlen out", 32'(cfg_tx_wordlen), 32'h3F);
        bus_write(6'h0C, 32'hFFFF_FFFF); read_check("R2 rxfmt", 6'h0C, 32'hFF);
        bus_write(6'h10, 32'hFFFF_FFFF); read_check("R2 frame", 6'h10, 32'hC000);
        check("R2 frame pol out", 32'(cfg_frame_pol), 32'h1);
        bus_write(6'h18, 32'hFFFF_FFFF); read_check("R2 mask", 6'h18, 32'h19);
        bus_write(6'h18, 32'h0);
        bus_write(6'h20, 32'h0000_0F0F); read_check("R8 thresholds", 6'h20, 32'h0F0F);
        check("R8 rx thresh out", 32'(cfg_rx_thresh), 32'hF);

        // R3 transmit order
        tx_send(32'hA1, 1); tx_send(32'hB2, 1); tx_send(32'hC3, 1);
        eng_take("R3 order"); eng_take("R3 order"); eng_take("R3 order");
        check("R3 drained", 32'(eng_tx_valid), 32'h0);

        // R4 full transmit FIFO
        for (int i = 0; i < 8; i++) tx_send(32'h1000 + i, 1);
        read_check("R4 status full", 6'h14, 32'h0);
        tx_send(32'hDEAD, 0);
        for (int i = 0; i < 8; i++) eng_take("R4 after full");
        check("R4 extra dropped", 32'(eng_tx_valid), 32'h0);

        // R5 receive order
        eng_push(32'h55, 1); eng_push(32'h66, 1); eng_push(32'h77, 1);
        read_check("R5 status", 6'h14, 32'h21);
        rx_drain("R5 order");
        read_check("R5 empty status", 6'h14, 32'h20);

        // R6 empty read
        read_check("R6 empty read", 6'h24, 32'h0);
        read_check("R6 status unchanged", 6'h14, 32'h20);
        eng_push(32'h99, 1);
        rx_drain("R6 next word");

        // R7 overrun
        for (int i = 0; i < 8; i++) eng_push(32'h200 + i, 1);
        eng_push(32'hBAD, 0);
        read_check("R7 flag", 6'h1C, 32'h01);

        // R10 irq masking
        check("R10 masked", 32'(irq), 32'h0);
        bus_write(6'h18, 32'h01);
        check("R10 unmasked", 32'(irq), 32'h1);
        bus_write(6'h18, 32'h18);
        check("R10 other masks", 32'(irq), 32'h0);

        rx_drain("R7 discard");
        read_check("R7 empty after", 6'h24, 32'h0);

        // R9 write-one-to-clear
        bus_write(6'h1C, 32'h0);
        read_check("R9 zero write", 6'h1C, 32'h01);
        bus_write(6'h1C, 32'h01);
        read_check("R9 cleared", 6'h1C, 32'h0);

        // R11 receive level
        bus_write(6'h20, 32'h0000_0002);
        eng_push(32'h31, 1);
        read_check("R11 below", 6'h1C, 32'h0);
        eng_push(32'h32, 1);
        read_check("R11 reached", 6'h1C, 32'h08);
        check("R10 rxl irq", 32'(irq), 32'h1);
        bus_write(6'h1C, 32'h08);
        rx_drain("R11 data");

        // R12 done pulse and busy
        @(negedge clk); eng_done = 1'b1;
        @(negedge clk); eng_done = 1'b0;
        read_check("R12 done flag", 6'h1C, 32'h10);
        eng_busy = 1'b1;
        read_check("R12 busy", 6'h14, 32'hA0);
        eng_busy = 1'b0;
        bus_write(6'h1C, 32'h19);

        // R8 flush
        tx_send(32'h1, 0); tx_send(32'h2, 0); tx_send(32'h3, 0);
        bus_write(6'h20, 32'h0000_1000);
        read_check("R8 flush reads 0", 6'h20, 32'h0);
        check("R8 tx flushed", 32'(eng_tx_valid), 32'h0);
        eng_push(32'h4, 0); eng_push(32'h5, 0);
        bus_write(6'h20, 32'h0000_0010);
        @(negedge clk);
        read_check("R8 rx flushed", 6'h14, 32'h20);
        read_check("R8 rx empty read", 6'h24, 32'h0);

        done = 1;
        summary();
        $finish;
    end
endmodule